// File: doc/BRIEF.md
# Dual-Channel Down-Counting Reload Timer

This peripheral holds two independent down-counting channels behind a single-cycle register port. Each channel has a control word, a readable running count and a fixed count that serves as the reload value. Software arms a one-shot event by writing a new fixed count while the channel's immediate-load bit is set. With auto-reload on, the channel runs forever and serves as a monotonic time base: software reads elapsed ticks by bit-inverting the running count. A sticky event flag, gated by an enable bit, drives one interrupt line per channel.

Each writable register has three write addresses: a plain write that replaces the value, a set alias that ORs in the written bits and a clear alias that removes them. Single bits can therefore change without a read-modify-write. A constant identification word reports major version 2. The slow reference tick is modelled as a qualifier input that is already synchronous to the bus clock.

Top module: `dual_down_timer`

## Requirements
- R1: After reset all control words, fixed counts, running counts, all event flags and the global word are zero and both interrupt lines are low; address 0x120 reads 0x0200_0000 (major version 2 in bits [31:24]).
- R2: The global word (0x00), each control word (0x20 + n*0x40) and each fixed count (0x40 + n*0x40) take a plain write at offset +0x0 (replace), a set write at +0x4 (OR) and a clear write at +0x8 (AND-NOT); a read at any of the three offsets returns the register.
- R3: Control bits [3:0] pick the tick: code 0xF ticks on every clock, code 0xB ticks on each clock where `slow_tick` is high, and every other code, 0 included, halts the channel.
- R4: The running count reads at 0x30 + n*0x40 and drops by exactly one on each selected tick; writes to that address change nothing.
- R5: While control bit 7 (immediate load) is set, a write to the fixed count also loads the resulting value into the running count in the same cycle, overriding a tick in that cycle; with bit 7 clear the running count is untouched.
- R6: With control bit 6 (auto-reload) set, a tick at count 1 loads the fixed count, so the period is the fixed count in ticks; a fixed count of 0xFFFF_FFFF gives a free-running count whose inversion equals elapsed ticks.
- R7: With bit 6 clear, a tick at count 1 goes to 0, and further ticks at 0 leave the count at 0 and raise no event.
- R8: Control bit 15 is a sticky event flag, set by the tick that takes the count from 1 to the terminal point (to 0 or to a reload); only a clear-alias write with bit 15 high clears it, plain and set writes leave it alone, and a set in the same cycle as a clear wins.
- R9: `irq[n]` is high exactly when channel n's flag and its enable bit 14 are both set.
- R10: Channels are independent: accesses and ticks on one channel leave the other's registers unchanged.
- R11: Unused control bits read 0; unmapped, misaligned and offset +0xC addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| slow_tick | input | 1 | Slow reference tick qualifier, one clock wide |
| irq | output | NUM_CH (2) | Per-channel interrupt, flag AND enable |

## Verification
The bench sweeps small fixed counts with and without auto-reload, counting slow ticks one by one and comparing the count, flag and interrupt to an arithmetic model; a design that reloads one tick early or late, or wraps a stopped counter to all ones, shows a wrong count within a single period. It drives a clear-alias flag write into the very cycle the counter reaches its terminal point, where a design that lets the clear win loses an event. It checks that a write with immediate load lands exactly in the load cycle, that halted codes freeze the count, and that plain or set writes to the flag bit do nothing, which catches a flag stored as an ordinary control bit.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUT  = 2'd1,
    OP_OR   = 2'd2,
    OP_ANDN = 2'd3
  } wr_op_e;

  localparam int SEL_W      = 4;
  localparam int RELOAD_BIT = 6;
  localparam int UPDATE_BIT = 7;
  localparam int IEN_BIT    = 14;
  localparam int FLAG_BIT   = 15;

  localparam logic [SEL_W-1:0] SEL_EVERY = 4'hF;
  localparam logic [SEL_W-1:0] SEL_SLOW  = 4'hB;

  // configuration bits kept in the control word (select, reload, update, enable)
  localparam word_t CFG_MASK = 32'h0000_40CF;

  // Apply a plain, set or clear write to a stored word.
  function automatic word_t merge_word(word_t cur, word_t wd, wr_op_e op);
    word_t r;
    case (op)
      OP_PUT:  r = wd;
      OP_OR:   r = cur | wd;
      OP_ANDN: r = cur & ~wd;
      default: r = cur;
    endcase
    return r;
  endfunction

  // Whether a channel advances in this clock.
  function automatic logic tick_active(logic [SEL_W-1:0] sel, logic slow);
    return (sel == SEL_EVERY) || ((sel == SEL_SLOW) && slow);
  endfunction

  // Count after one tick.
  function automatic word_t step_count(word_t cnt, word_t fix, logic reload);
    word_t r;
    if (cnt == '0)               r = '0;
    else if (cnt == word_t'(1))  r = reload ? fix : '0;
    else                         r = cnt - word_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/ddt_decode.sv
module ddt_decode
  import ddt_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_CH   = 2,
  parameter int VER_ADDR = 'h120
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_op_e            op,
  output logic              glb_hit,
  output logic              ver_hit,
  output logic [NUM_CH-1:0] ctrl_hit,
  output logic [NUM_CH-1:0] cnt_hit,
  output logic [NUM_CH-1:0] fix_hit
);
  localparam logic [ADDR_W-1:0] VER_BASE = ADDR_W'(VER_ADDR);

  logic              aligned;
  logic [1:0]        alias_f;
  logic              valid;
  logic [ADDR_W-1:0] blk;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign alias_f = bus_addr[3:2];
  assign valid   = aligned && (alias_f != 2'b11);
  assign blk     = {bus_addr[ADDR_W-1:4], 4'h0};

  always_comb begin
    op = OP_NONE;
    if (bus_wr && valid) begin
      case (alias_f)
        2'b00:   op = OP_PUT;
        2'b01:   op = OP_OR;
        default: op = OP_ANDN;
      endcase
    end
  end

  assign glb_hit = valid && (blk == '0);
  assign ver_hit = valid && (blk == VER_BASE);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(32'h20 + 32'h40 * i);
    localparam logic [ADDR_W-1:0] CNT_BASE  = ADDR_W'(32'h30 + 32'h40 * i);
    localparam logic [ADDR_W-1:0] FIX_BASE  = ADDR_W'(32'h40 + 32'h40 * i);
    assign ctrl_hit[i] = valid && (blk == CTRL_BASE);
    assign cnt_hit[i]  = valid && (blk == CNT_BASE);
    assign fix_hit[i]  = valid && (blk == FIX_BASE);
  end
endmodule

// File: rtl/ddt_channel.sv
module ddt_channel
  import ddt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic   clk,
  input  logic   rst_n,
  input  wr_op_e op,
  input  logic   ctrl_hit,
  input  logic   fix_hit,
  input  word_t  wdata,
  input  logic   slow_tick,
  output word_t  ctrl_rd,
  output word_t  cnt_rd,
  output word_t  fix_rd,
  output logic   irq
);
  word_t            cfg_q;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] fix_q;

  // named internal events
  logic             ctrl_wr;
  logic             fix_wr;
  logic             flag_clr;
  logic             fx_load;
  logic             tick;
  logic             zero_hit;
  logic             reload;
  logic [CNT_W-1:0] fix_next;
  logic [CNT_W-1:0] cnt_step;

  assign ctrl_wr  = ctrl_hit && (op != OP_NONE);
  assign fix_wr   = fix_hit && (op != OP_NONE);
  assign flag_clr = ctrl_wr && (op == OP_ANDN) && wdata[FLAG_BIT];
  assign reload   = cfg_q[RELOAD_BIT];
  assign fix_next = CNT_W'(merge_word(word_t'(fix_q), wdata, op));
  assign fx_load  = fix_wr && cfg_q[UPDATE_BIT];
  assign tick     = tick_active(cfg_q[SEL_W-1:0], slow_tick);
  assign zero_hit = tick && !fx_load && (cnt_q == CNT_W'(1));
  assign cnt_step = CNT_W'(step_count(word_t'(cnt_q), word_t'(fix_q), reload));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
      fix_q  <= '0;
    end else begin
      if (ctrl_wr) cfg_q <= merge_word(cfg_q, wdata, op) & CFG_MASK;
      if (fix_wr)  fix_q <= fix_next;
      if (fx_load)   cnt_q <= fix_next;
      else if (tick) cnt_q <= cnt_step;
      // a terminal tick beats a clear in the same cycle
      flag_q <= zero_hit || (flag_q && !flag_clr);
    end
  end

  always_comb begin
    ctrl_rd           = cfg_q;
    ctrl_rd[FLAG_BIT] = flag_q;
  end
  assign cnt_rd = word_t'(cnt_q);
  assign fix_rd = word_t'(fix_q);
  assign irq    = flag_q && cfg_q[IEN_BIT];

  // R3
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fx_load) |=> $stable(cnt_q));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fx_load && (cnt_q > CNT_W'(1))) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R5
  update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fx_load |=> (cnt_q == $past(fix_next)));

  // R7
  stop_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && (cnt_q == '0) && !fx_load) |=> (cnt_q == '0));

  // R8
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import ddt_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 32,
  parameter int VER_MAJOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              slow_tick,
  output logic [NUM_CH-1:0] irq
);
  localparam word_t VERSION_WORD = {8'(VER_MAJOR), 24'h0};

  wr_op_e            op;
  logic              glb_hit;
  logic              ver_hit;
  logic [NUM_CH-1:0] ctrl_hit;
  logic [NUM_CH-1:0] cnt_hit;
  logic [NUM_CH-1:0] fix_hit;
  word_t             glb_q;
  word_t             ctrl_rd [NUM_CH];
  word_t             cnt_rd  [NUM_CH];
  word_t             fix_rd  [NUM_CH];

  ddt_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .VER_ADDR('h120)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .op       (op),
    .glb_hit  (glb_hit),
    .ver_hit  (ver_hit),
    .ctrl_hit (ctrl_hit),
    .cnt_hit  (cnt_hit),
    .fix_hit  (fix_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                           glb_q <= '0;
    else if (glb_hit && (op != OP_NONE))  glb_q <= merge_word(glb_q, bus_wdata, op);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ddt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .ctrl_hit  (ctrl_hit[i]),
      .fix_hit   (fix_hit[i]),
      .wdata     (bus_wdata),
      .slow_tick (slow_tick),
      .ctrl_rd   (ctrl_rd[i]),
      .cnt_rd    (cnt_rd[i]),
      .fix_rd    (fix_rd[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (ver_hit) bus_rdata = VERSION_WORD;
    if (glb_hit) bus_rdata = bus_rdata | glb_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctrl_hit[i]) bus_rdata = bus_rdata | ctrl_rd[i];
      if (cnt_hit[i])  bus_rdata = bus_rdata | cnt_rd[i];
      if (fix_hit[i])  bus_rdata = bus_rdata | fix_rd[i];
    end
  end

  // R9
  irq_quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (irq == '0));

  // R1
  version_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ver_hit |-> (bus_rdata[31:24] == 8'(VER_MAJOR)));
endmodule

// File: tb/dual_down_timer_test.sv
module dual_down_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        slow_tick = 1'b0;
  logic [1:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_down_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_tick(slow_tick), .irq(irq)
  );

  function automatic logic [11:0] a_ctrl(int n, int al); return 12'(32'h20 + n * 32'h40 + al * 4); endfunction
  function automatic logic [11:0] a_cnt(int n);          return 12'(32'h30 + n * 32'h40); endfunction
  function automatic logic [11:0] a_fix(int n, int al);  return 12'(32'h40 + n * 32'h40 + al * 4); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic pulse_slow();
    @(negedge clk); slow_tick = 1'b1;
    @(negedge clk); slow_tick = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(a_ctrl(0, 0), v); chk("R1 ctrl0", v, 0);
    rd(a_ctrl(1, 0), v); chk("R1 ctrl1", v, 0);
    rd(a_cnt(0), v);     chk("R1 cnt0", v, 0);
    rd(a_fix(1, 0), v);  chk("R1 fix1", v, 0);
    rd(12'h000, v);      chk("R1 global", v, 0);
    rd(12'h120, v);      chk("R1 version", v, 32'h0200_0000);
    chk("R1 irq", {30'd0, irq}, 0);

    // R2 global word aliases
    wr(12'h000, 32'hA5A5_0000);
    wr(12'h004, 32'h0000_000F);
    wr(12'h008, 32'hA000_0000);
    rd(12'h000, v); chk("R2 global merge", v, 32'h05A5_000F);
    rd(12'h008, v); chk("R2 alias read", v, 32'h05A5_000F);

    // R3 R4 R5: every-clock tick, load lands in write cycle
    wr(a_ctrl(0, 0), 32'h0000_008F);
    wr(a_fix(0, 0), 32'd100);
    rd(a_cnt(0), v); chk("R5 load value", v, 100);
    repeat (7) @(negedge clk);
    rd(a_cnt(0), v); chk("R3 R4 every clock", v, 93);

    // R3 halt codes
    wr(a_ctrl(0, 0), 32'h0000_0080);
    wr(a_fix(0, 0), 32'd50);
    pulse_slow(); repeat (4) @(negedge clk);
    rd(a_cnt(0), v); chk("R3 code 0 halt", v, 50);
    wr(a_ctrl(0, 0), 32'h0000_0085);
    pulse_slow(); repeat (4) @(negedge clk);
    rd(a_cnt(0), v); chk("R3 code 5 halt", v, 50);

    // R5 no load without update bit
    wr(a_ctrl(0, 0), 32'h0);
    wr(a_fix(0, 0), 32'd9);
    rd(a_cnt(0), v); chk("R5 no update", v, 50);
    rd(a_fix(0, 0), v); chk("R5 fix stored", v, 9);

    // R2 fixed-count aliases
    wr(a_fix(0, 0), 32'h0F0);
    wr(a_fix(0, 1), 32'h00F);
    rd(a_fix(0, 0), v); chk("R2 fix set", v, 32'h0FF);
    wr(a_fix(0, 2), 32'h0F0);
    rd(a_fix(0, 1), v); chk("R2 fix clear", v, 32'h00F);

    // R4 running-count writes ignored
    wr(a_cnt(0), 32'h1234);
    wr(a_cnt(0) + 12'h4, 32'hFFFF);
    rd(a_cnt(0), v); chk("R4 cnt write ignored", v, 50);

    // R8 plain and set writes to flag ignored; R11 unused bits
    wr(a_ctrl(0, 0), 32'hFFFF_FFFF);
    rd(a_ctrl(0, 0), v); chk("R8 R11 plain write", v, 32'h0000_40CF);
    wr(a_ctrl(0, 1), 32'h0000_8000);
    rd(a_ctrl(0, 0), v); chk("R8 set alias flag", v, 32'h0000_40CF);
    chk("R9 no flag no irq", {31'd0, irq[0]}, 0);

    // R11 unmapped, alias 3, misaligned
    rd(12'h010, v); chk("R11 unmapped", v, 0);
    rd(12'h02C, v); chk("R11 offset C", v, 0);
    rd(12'h021, v); chk("R11 misaligned", v, 0);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h000, v); chk("R11 write ignored", v, 32'h05A5_000F);

    // Sweep: slow tick, small fixed counts, both reload settings
    for (int ch = 0; ch < 2; ch++) begin
      for (int rl = 0; rl < 2; rl++) begin
        for (int f = 1; f <= 5; f++) begin
          logic [31:0] cw;
          cw = 32'h0000_408B | (rl << 6);
          wr(a_ctrl(ch, 0), cw);
          wr(a_ctrl(ch, 2), 32'h0000_8000);
          wr(a_fix(ch, 0), f);
          for (int k = 0; k <= 2 * f + 1; k++) begin
            int  ecnt;
            bit  eflag;
            if (rl == 1) ecnt = f - (k % f);
            else         ecnt = (k >= f) ? 0 : f - k;
            eflag = (k >= f);
            rd(a_cnt(ch), v);
            if (rl == 1) chk("R6 reload count", v, ecnt);
            else         chk("R7 stop count", v, ecnt);
            rd(a_ctrl(ch, 0), v);
            chk("R8 flag in ctrl", v, cw | (32'(eflag) << 15));
            chk("R9 irq", {31'd0, irq[ch]}, {31'd0, eflag});
            pulse_slow();
          end
          wr(a_ctrl(ch, 2), 32'h0000_8000);
          rd(a_ctrl(ch, 0), v); chk("R8 clear alias", v, cw);
        end
      end
    end

    // R8 set beats clear in the same cycle
    wr(a_ctrl(0, 0), 32'h0000_408B);
    wr(a_ctrl(0, 2), 32'h0000_8000);
    wr(a_fix(0, 0), 32'd1);
    @(negedge clk);
    slow_tick = 1'b1; bus_wr = 1'b1; bus_addr = a_ctrl(0, 2); bus_wdata = 32'h0000_8000;
    @(negedge clk);
    slow_tick = 1'b0; bus_wr = 1'b0;
    rd(a_ctrl(0, 0), v); chk("R8 set wins", v, 32'h0000_C08B);
    rd(a_cnt(0), v);     chk("R7 hit zero", v, 0);

    // R9 enable gating via aliases
    wr(a_ctrl(0, 2), 32'h0000_4000);
    chk("R9 enable off", {31'd0, irq[0]}, 0);
    wr(a_ctrl(0, 1), 32'h0000_4000);
    chk("R9 enable on", {31'd0, irq[0]}, 1);
    wr(a_ctrl(0, 2), 32'h0000_C000);
    chk("R9 cleared", {31'd0, irq[0]}, 0);

    // R6 maximum period, elapsed by inversion; R10 independence
    wr(a_ctrl(0, 0), 32'h0000_0080);
    wr(a_fix(0, 0), 32'd777);
    wr(a_ctrl(1, 0), 32'h0000_00CF);
    wr(a_fix(1, 0), 32'hFFFF_FFFF);
    repeat (37) @(negedge clk);
    rd(a_cnt(1), v); chk("R6 elapsed", ~v, 37);
    rd(a_cnt(0), v); chk("R10 ch0 untouched", v, 777);
    rd(a_fix(0, 0), v); chk("R10 ch0 fix", v, 777);
    rd(a_ctrl(0, 0), v); chk("R10 ch0 ctrl", v, 32'h0000_0080);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule